// File: doc/BRIEF.md
# Fan Tachometer Pulse Period Monitor

This block times the interval between rising edges of a fan tachometer signal, one channel per fan. Each channel runs an 8-bit up-counter that is clocked by a slow timebase tick. The tick comes from a 32.768 kHz enable, which a per-channel power-of-two prescaler slows down further. On every tach rising edge the channel saves the finished count into a latch that the host can read. It then restarts the counter from a programmable starting value instead of from zero.

The starting value lets a fixed limit of 192 stand for any chosen speed. The count for one pulse period is half of 1.966e6 divided by (RPM × prescale), because the fan gives two pulses per revolution. Firmware loads 192 minus the count expected at the trip speed. A fan slower than that speed then pushes the counter to 192 or above, which raises the threshold flag. The counter stops at 0xFF and does not wrap, so a stalled fan keeps the flag raised. A rising threshold sets a sticky status bit. That bit feeds a shared interrupt line when its enable is set.

All register-side inputs are single-cycle strobes or static levels in the system clock domain. The tach inputs are asynchronous and are resynchronized inside the block.

Top module: `fan_tach_monitor`

## Requirements
- R1: The pulse counter saturates at 0xFF. Once at 0xFF it stays there until a tach edge or a preload write, and it never wraps to 0x00.
- R2: A tach rising edge reloads the counter from the stored preload. The tach input passes through a two-flop synchronizer, so the reload happens at the third rising clock edge after the tach input goes high.
- R3: A preload write strobe stores the write data as the preload and loads it into the counter at the next clock edge. If a write and a tach edge land in the same cycle, the counter takes the written value.
- R4: The read latch takes the counter value held just before a tach edge, in the same cycle as the reload of R2. At all other times it keeps its value.
- R5: The threshold output is the AND of counter bits 7 and 6. It is 1 exactly when the count is 192 or more.
- R6: The status bit is set in the clock cycle after the threshold output rises, and it stays set until a write-1 clear strobe. If a set and a clear land in the same cycle, the set wins.
- R7: The interrupt output is 1 when any channel has both its status bit and its enable input at 1.
- R8: Each channel's 2-bit prescale select s (0..3) divides the timebase by 2^s. A 3-bit divider counts timebase ticks from reset, and it increments on every tick. The counter advances on a tick when the low s bits of that divider are all ones. A reload (R2, R3) takes priority over an advance.
- R9: After reset the counter, preload, latch, threshold, status and interrupt are all 0.
- R10: The two channels are independent. Stimulus on one channel never changes the other channel's latch, threshold or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tb_tick_i | input | 1 | One-cycle 32.768 kHz timebase enable |
| tach_i | input | 2 | Asynchronous tach inputs, one per fan |
| presc_sel_i | input | 4 | Prescale select, 2 bits per fan (fan 0 in bits 1:0) |
| irq_en_i | input | 2 | Interrupt enable per fan |
| preload_wr_i | input | 2 | Preload write strobe per fan |
| wdata_i | input | 8 | Preload write data |
| stat_clr_i | input | 2 | Write-1-to-clear strobe for status, per fan |
| latch_o | output | 16 | Read latches, 8 bits per fan (fan 0 in bits 7:0) |
| over_o | output | 2 | Threshold outputs (count at or above 192) |
| stat_o | output | 2 | Sticky status bits |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The latch value and the counter reload of a tach edge are due at the third clock edge after the tach input rises. A preload write reaches the counter and the threshold output at the first edge, and status follows one edge after the threshold rises. The interrupt output follows status with no added delay. The bench drives inputs on falling edges. It keeps a cycle-accurate model that it updates on each rising edge, and it compares all outputs 2 ns after that edge, so every result is sampled in the cycle it becomes due. Directed sequences place a preload write exactly on the reload cycle, hold a channel at saturation, and measure the count rate under the slowest prescale.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W = 8;
    localparam int SEL_W = 2;
    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        count_t cnt;
        count_t pre;
        count_t lat;
        logic   thr_prev;
        logic   stat;
    } chan_state_t;

endpackage

// File: rtl/tach_edge_detect.sv
module tach_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tach_i,
    output logic rise_o
);
    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d    = {sr_q[SR_W-2:0], tach_i};
        rise_o  = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import fan_tach_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = (1 << SW) - 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [SW-1:0] sel_i,
    output logic          adv_o
);
    logic [DW-1:0] div_d, div_q;
    logic [DW-1:0] mask;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(sel_i));
        end
        div_d = div_q + DW'(tick_i);
        adv_o = tick_i & ((div_q & mask) == mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    AST_ADV_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(div_q)); // R8

endmodule

// File: rtl/period_channel.sv
module period_channel
    import fan_tach_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   rise_i,
    input  logic   adv_i,
    input  logic   wr_i,
    input  count_t wdata_i,
    input  logic   clr_i,
    input  logic   en_i,
    output count_t latch_o,
    output logic   over_o,
    output logic   stat_o,
    output logic   irq_o
);
    chan_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        over_o       = s_q.cnt[CNT_W-1] & s_q.cnt[CNT_W-2];
        s_d.thr_prev = over_o;
        s_d.stat     = (s_q.stat & ~clr_i) | (over_o & ~s_q.thr_prev);
        if (rise_i) begin
            s_d.lat = s_q.cnt;
        end
        if (wr_i) begin
            s_d.pre = wdata_i;
            s_d.cnt = wdata_i;
        end else if (rise_i) begin
            s_d.cnt = s_q.pre;
        end else if (adv_i && (s_q.cnt != '1)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        latch_o = s_q.lat;
        stat_o  = s_q.stat;
        irq_o   = s_q.stat & en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt == '1 && !wr_i && !rise_i) |=> (s_q.cnt == '1)); // R1
    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt != '0 && !wr_i && !rise_i) |=> (s_q.cnt != '0)); // R1
    AST_EDGE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && !wr_i) |=> (s_q.cnt == $past(s_q.pre))); // R2
    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (s_q.cnt == $past(wdata_i) && s_q.pre == $past(wdata_i))); // R3
    AST_LATCH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> (latch_o == $past(s_q.cnt))); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rise_i |=> $stable(latch_o)); // R4
    AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(over_o) |=> stat_o); // R6
    AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o && !clr_i) |=> stat_o); // R6

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      tb_tick_i,
    input  logic [NUM_FANS-1:0]       tach_i,
    input  logic [NUM_FANS*SEL_W-1:0] presc_sel_i,
    input  logic [NUM_FANS-1:0]       irq_en_i,
    input  logic [NUM_FANS-1:0]       preload_wr_i,
    input  logic [CNT_W-1:0]          wdata_i,
    input  logic [NUM_FANS-1:0]       stat_clr_i,
    output logic [NUM_FANS*CNT_W-1:0] latch_o,
    output logic [NUM_FANS-1:0]       over_o,
    output logic [NUM_FANS-1:0]       stat_o,
    output logic                      irq_o
);
    logic [NUM_FANS-1:0] rise;
    logic [NUM_FANS-1:0] adv;
    logic [NUM_FANS-1:0] irq_ch;

    for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
        tach_edge_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .tach_i(tach_i[f]),
            .rise_o(rise[f])
        );

        tick_divider u_div (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .tick_i(tb_tick_i),
            .sel_i (presc_sel_i[f*SEL_W +: SEL_W]),
            .adv_o (adv[f])
        );

        period_channel u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .rise_i (rise[f]),
            .adv_i  (adv[f]),
            .wr_i   (preload_wr_i[f]),
            .wdata_i(wdata_i),
            .clr_i  (stat_clr_i[f]),
            .en_i   (irq_en_i[f]),
            .latch_o(latch_o[f*CNT_W +: CNT_W]),
            .over_o (over_o[f]),
            .stat_o (stat_o[f]),
            .irq_o  (irq_ch[f])
        );
    end

    assign irq_o = |irq_ch;

    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|(stat_o & irq_en_i))); // R7

endmodule

// File: tb/fan_tach_monitor_test.sv
module fan_tach_monitor_test;
    localparam int N = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tb_tick = 1'b0;
    logic [N-1:0]  tach = '0;
    logic [2*N-1:0] sel = '0;
    logic [N-1:0]  en = '0;
    logic [N-1:0]  wr = '0;
    logic [7:0]    wdata = '0;
    logic [N-1:0]  clr = '0;
    logic [8*N-1:0] latch;
    logic [N-1:0]  over;
    logic [N-1:0]  stat;
    logic          irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    bit  tick_on = 0;
    int  tick_div = 1;
    bit  model_chk = 0;

    // bench model state
    logic [7:0] m_cnt [N];
    logic [7:0] m_pre [N];
    logic [7:0] m_lat [N];
    logic [2:0] m_div [N];
    logic       m_s1 [N], m_s2 [N], m_s3 [N];
    logic       m_thrp [N], m_stat [N];

    always #5 clk = ~clk;

    fan_tach_monitor uut (
        .clk_i(clk), .rst_ni(rst_n), .tb_tick_i(tb_tick), .tach_i(tach),
        .presc_sel_i(sel), .irq_en_i(en), .preload_wr_i(wr), .wdata_i(wdata),
        .stat_clr_i(clr), .latch_o(latch), .over_o(over), .stat_o(stat), .irq_o(irq)
    );

    function automatic logic [2:0] sel_mask(input logic [1:0] s);
        return 3'((4'd1 << s) - 4'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) tb_tick <= tick_on && ($urandom % tick_div == 0);

    always @(posedge clk) begin
        for (int f = 0; f < N; f++) begin
            if (!rst_n) begin
                m_cnt[f] = 0; m_pre[f] = 0; m_lat[f] = 0; m_div[f] = 0;
                m_s1[f] = 0; m_s2[f] = 0; m_s3[f] = 0; m_thrp[f] = 0; m_stat[f] = 0;
            end else begin
                logic ed, ad, th;
                ed = m_s2[f] && !m_s3[f];
                ad = tb_tick && ((m_div[f] & sel_mask(sel[2*f +: 2])) == sel_mask(sel[2*f +: 2])); // R8
                th = (m_cnt[f] >= 8'd192);
                m_stat[f] = (m_stat[f] && !clr[f]) || (th && !m_thrp[f]);
                m_thrp[f] = th;
                if (ed) m_lat[f] = m_cnt[f];
                if (wr[f]) begin m_cnt[f] = wdata; m_pre[f] = wdata; end
                else if (ed) m_cnt[f] = m_pre[f];               // R2
                else if (ad && m_cnt[f] != 8'hFF) m_cnt[f] = m_cnt[f] + 8'd1;
                m_div[f] = m_div[f] + 3'(tb_tick);
                m_s3[f] = m_s2[f]; m_s2[f] = m_s1[f]; m_s1[f] = tach[f];
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (model_chk && rst_n) begin
            bit any;
            any = 0;
            for (int f = 0; f < N; f++) begin
                chk(latch[8*f +: 8] == m_lat[f], f ? "R4 R10 latch fan1" : "R4 latch fan0",
                    latch[8*f +: 8], m_lat[f]);
                chk(over[f] == (m_cnt[f] >= 8'd192), "R5 threshold", over[f], m_cnt[f] >= 8'd192);
                chk(stat[f] == m_stat[f], "R6 status", stat[f], m_stat[f]);
                any |= m_stat[f] && en[f];
            end
            chk(irq == any, "R7 interrupt", irq, any);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_pre(input int f, input logic [7:0] v);
        @(negedge clk); wr[f] = 1'b1; wdata = v;
        @(negedge clk); wr[f] = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R9 reset state
        chk(latch == '0, "R9 latch", latch, 0);
        chk(over == '0, "R9 threshold", over, 0);
        chk(stat == '0, "R9 status", stat, 0);
        chk(irq == 1'b0, "R9 irq", irq, 0);
        model_chk = 1;

        // R1 / R5 / R6 / R7 saturation on fan 0
        tick_on = 1; tick_div = 1; sel = '0;
        write_pre(0, 8'd250);
        chk(over[0] == 1'b1, "R5 preload 250 over", over[0], 1);
        cyc(30);
        tach[0] = 1'b1; cyc(4);
        chk(latch[7:0] == 8'hFF, "R1 saturated latch", latch[7:0], 255);
        chk(stat[0] == 1'b1, "R6 status set", stat[0], 1);
        chk(irq == 1'b0, "R7 masked irq", irq, 0);
        chk(latch[15:8] == 8'd0, "R10 fan1 untouched", latch[15:8], 0);
        en[0] = 1'b1; cyc(1);
        chk(irq == 1'b1, "R7 enabled irq", irq, 1);
        clr[0] = 1'b1; cyc(1); clr[0] = 1'b0; cyc(1);
        chk(stat[0] == 1'b0, "R6 cleared", stat[0], 0);
        chk(irq == 1'b0, "R7 irq after clear", irq, 0);
        tach[0] = 1'b0; en[0] = 1'b0;

        // R3 collision on fan 1, no ticks
        tick_on = 0; cyc(2);
        write_pre(1, 8'd100);
        tach[1] = 1'b1; cyc(2);
        wr[1] = 1'b1; wdata = 8'd33; cyc(1); wr[1] = 1'b0;
        cyc(2);
        chk(latch[15:8] == 8'd100, "R3 collision latch old", latch[15:8], 100);
        tach[1] = 1'b0; cyc(4); tach[1] = 1'b1; cyc(5);
        chk(latch[15:8] == 8'd33, "R2 R3 reload new preload", latch[15:8], 33);
        tach[1] = 1'b0;

        // R8 slowest prescale on fan 0
        sel[1:0] = 2'd3; tick_on = 1; tick_div = 1;
        write_pre(0, 8'd0);
        cyc(63);
        tach[0] = 1'b1; cyc(4);
        chk(latch[7:0] >= 8'd7 && latch[7:0] <= 8'd9, "R8 divide by 8", latch[7:0], 8);
        tach[0] = 1'b0; cyc(4);

        // random phase
        tick_div = 2;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            wr = '0; clr = '0;
            for (int f = 0; f < N; f++) begin
                if ($urandom % 40 == 0) tach[f] = ~tach[f];
                if ($urandom % 30 == 0) clr[f] = 1'b1;
                if ($urandom % 50 == 0) en[f] = ~en[f];
                if ($urandom % 400 == 0) sel[2*f +: 2] = 2'($urandom);
            end
            if ($urandom % 150 == 0) begin
                int f;
                f = $urandom % N;
                wr[f] = 1'b1;
                wdata = 8'(120 + $urandom % 136);
            end
        end
        @(negedge clk); wr = '0; clr = '0;
        cyc(2);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        #1500000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule